// File: doc/BRIEF.md
# Serial Loopback Frame Receiver with CRC and Address Status

This block sits behind the serial input of a network controller's receive path. While it waits for a frame it examines the incoming bit stream. Alternating preamble bits are thrown away, and the frame starts only when the start-of-frame delimiter has been seen. From that point the block packs bits into bytes, least significant bit first. It emits each completed byte with a one-cycle strobe and keeps a running count of the bytes received in the current frame.

A frame ends when the bit-valid input falls. At that moment the block latches a three-bit receive status. The status is built from a CRC-32 check run over every received byte, from a CRC-inhibit control and from an address-match verdict supplied by an external filter. When the CRC check is inhibited the status rules change: a CRC error is forced for frames the filter accepts, and frames it rejects report no CRC error. Loopback diagnostics depend on these rules. Every finished frame reports packet-received, whether or not the address matched.

Top module: `lbk_rx`

## Requirements
- R1: While reset is held, and in the cycle after it is released, byte_vld, eof, byte_cnt and all three status outputs are 0.
- R2: In the hunting state no byte is emitted and eof is never raised. A frame starts only when the last eight valid bits, in arrival order, are 1,0,1,0,1,0,1,1 (the byte 0xD5 sent LSB first). A drop of bit_vld during hunting clears any partly matched pattern.
- R3: After the delimiter, each group of eight valid bits forms one byte. The first bit to arrive is bit 0. byte_vld is high for exactly one cycle, the cycle after the edge that sampled the eighth bit, and byte_data carries the byte in that cycle.
- R4: byte_cnt becomes 0 in the cycle after the delimiter completes. It rises by one in the same cycle as each byte_vld pulse, and otherwise holds its value, including after the frame ends.
- R5: The first low sample of bit_vld inside a frame raises eof for exactly one cycle, in the cycle after that edge. Any bits after the last whole byte produce no byte and do not change byte_cnt.
- R6: With crc_inhibit low at frame end, stat_crc_err is 0 exactly when the CRC-32 over all received bytes leaves the fixed residue. This holds when the last four bytes are the complement of the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones) of the earlier bytes, sent low byte first. The result does not depend on addr_hit.
- R7: With crc_inhibit high at frame end, no CRC check is done: stat_crc_err equals addr_hit. A frame that carries a correct CRC therefore still shows a CRC error when it matches.
- R8: stat_pkt_rx is 1 after every frame end, including frames whose address did not match.
- R9: stat_intact is 1 after frame end only when addr_hit was 1 and stat_crc_err is 0.
- R10: The status is sampled from crc_inhibit and addr_hit on the edge where bit_vld is first seen low. It becomes visible together with eof, and holds regardless of those inputs until the next delimiter completes, which clears all three bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | bit_in carries a bit this cycle; a drop ends a frame |
| crc_inhibit | input | 1 | Skip the CRC check and apply the forced-error rule |
| addr_hit | input | 1 | Address filter accepted the frame (sampled at frame end) |
| byte_data | output | 8 | Last assembled byte |
| byte_vld | output | 1 | One-cycle strobe for byte_data |
| eof | output | 1 | One-cycle end-of-frame strobe |
| byte_cnt | output | CNT_W | Bytes received since the delimiter |
| stat_intact | output | 1 | Frame matched and no CRC error |
| stat_crc_err | output | 1 | CRC error, real or forced |
| stat_pkt_rx | output | 1 | A frame has ended |

## Verification
Every result here comes one register after the edge that causes it. A byte and its count appear in the cycle after the edge that sampled its eighth bit. The cleared count and the cleared status appear in the cycle after the edge that sampled the last delimiter bit. eof and the new status appear in the cycle after the edge that first sees bit_vld low. The bench changes inputs on falling edges and reads outputs 2 ns after the next rising edge, so each check falls in the exact cycle where its result is due. It also confirms that byte_vld stays low for the seven bits before each byte, and that the status holds for several cycles while crc_inhibit and addr_hit are toggled.

// File: rtl/lbk_rx_pkg.sv
package lbk_rx_pkg;

    localparam int          BYTE_W      = 8;
    localparam int          IDX_W       = $clog2(BYTE_W);
    localparam logic [7:0]  SYNC_PAT    = 8'hD5;
    localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_DATA = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic intact;
        logic crc_err;
        logic pkt_rx;
    } rx_status_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] c,
                                               input logic [BYTE_W-1:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/lbk_rx_deser.sv
module lbk_rx_deser
    import lbk_rx_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_vld,
    output logic              sync_hit,
    output logic              asm_done,
    output logic              frame_end,
    output logic [BYTE_W-1:0] asm_byte,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_vld,
    output logic              eof,
    output logic [CNT_W-1:0]  byte_cnt
);

    rx_state_e         st;
    logic [BYTE_W-1:0] win;
    logic [BYTE_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] win_next;

    assign win_next  = {bit_in, win[BYTE_W-1:1]};
    assign sync_hit  = (st == ST_HUNT) && bit_vld && (win_next == SYNC_PAT);
    assign asm_byte  = {bit_in, shreg[BYTE_W-1:1]};
    assign asm_done  = (st == ST_DATA) && bit_vld && (bit_idx == IDX_W'(BYTE_W - 1));
    assign frame_end = (st == ST_DATA) && !bit_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_HUNT;
            win       <= '0;
            shreg     <= '0;
            bit_idx   <= '0;
            byte_data <= '0;
            byte_vld  <= 1'b0;
            eof       <= 1'b0;
            byte_cnt  <= '0;
        end else begin
            byte_vld <= asm_done;
            eof      <= frame_end;
            if (asm_done) byte_data <= asm_byte;
            case (st)
                ST_HUNT: begin
                    if (!bit_vld) begin
                        win <= '0;
                    end else if (sync_hit) begin
                        st       <= ST_DATA;
                        win      <= '0;
                        bit_idx  <= '0;
                        byte_cnt <= '0;
                    end else begin
                        win <= win_next;
                    end
                end
                default: begin
                    if (!bit_vld) begin
                        st <= ST_HUNT;
                    end else begin
                        shreg   <= asm_byte;
                        bit_idx <= bit_idx + 1'b1;
                        if (asm_done) byte_cnt <= byte_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/lbk_rx_crc.sv
module lbk_rx_crc
    import lbk_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_hit,
    input  logic              asm_done,
    input  logic [BYTE_W-1:0] asm_byte,
    output logic              crc_ok
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || sync_hit) crc_q <= CRC_SEED;
        else if (asm_done)   crc_q <= crc32_step(crc_q, asm_byte);
    end

    assign crc_ok = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/lbk_rx_status.sv
module lbk_rx_status
    import lbk_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_hit,
    input  logic       frame_end,
    input  logic       crc_ok,
    input  logic       crc_inhibit,
    input  logic       addr_hit,
    output rx_status_t stat
);

    rx_status_t stat_next;

    always_comb begin
        stat_next.pkt_rx  = 1'b1;
        stat_next.crc_err = crc_inhibit ? addr_hit : !crc_ok;
        stat_next.intact  = addr_hit && !stat_next.crc_err;
    end

    always_ff @(posedge clk) begin
        if (rst || sync_hit) stat <= '0;
        else if (frame_end)  stat <= stat_next;
    end

endmodule

// File: rtl/lbk_rx.sv
module lbk_rx
    import lbk_rx_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              crc_inhibit,
    input  logic              addr_hit,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_vld,
    output logic              eof,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic              stat_intact,
    output logic              stat_crc_err,
    output logic              stat_pkt_rx
);

    logic              sync_hit;
    logic              asm_done;
    logic              frame_end;
    logic [BYTE_W-1:0] asm_byte;
    logic              crc_ok;
    rx_status_t        stat;

    lbk_rx_deser #(.CNT_W(CNT_W)) u_deser (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .bit_vld   (bit_vld),
        .sync_hit  (sync_hit),
        .asm_done  (asm_done),
        .frame_end (frame_end),
        .asm_byte  (asm_byte),
        .byte_data (byte_data),
        .byte_vld  (byte_vld),
        .eof       (eof),
        .byte_cnt  (byte_cnt)
    );

    lbk_rx_crc u_crc (
        .clk      (clk),
        .rst      (rst),
        .sync_hit (sync_hit),
        .asm_done (asm_done),
        .asm_byte (asm_byte),
        .crc_ok   (crc_ok)
    );

    lbk_rx_status u_status (
        .clk         (clk),
        .rst         (rst),
        .sync_hit    (sync_hit),
        .frame_end   (frame_end),
        .crc_ok      (crc_ok),
        .crc_inhibit (crc_inhibit),
        .addr_hit    (addr_hit),
        .stat        (stat)
    );

    assign stat_intact  = stat.intact;
    assign stat_crc_err = stat.crc_err;
    assign stat_pkt_rx  = stat.pkt_rx;

endmodule

// File: rtl/lbk_rx_chk.sv
module lbk_rx_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             crc_inhibit,
    input logic             addr_hit,
    input logic             byte_vld,
    input logic             eof,
    input logic [CNT_W-1:0] byte_cnt,
    input logic             stat_intact,
    input logic             stat_crc_err,
    input logic             stat_pkt_rx,
    input logic             sync_hit
);

    logic [2:0] stat_bits;
    assign stat_bits = {stat_intact, stat_crc_err, stat_pkt_rx};

    // R3
    byte_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> byte_cnt == CNT_W'($past(byte_cnt) + 1'b1));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!byte_vld && !$past(sync_hit)) |-> $stable(byte_cnt));

    // R5
    eof_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eof |=> !eof);

    // R5
    eof_no_byte_chk: assert property (@(posedge clk) disable iff (rst)
        eof |-> !byte_vld);

    // R7
    inh_err_chk: assert property (@(posedge clk) disable iff (rst)
        (eof && $past(crc_inhibit)) |-> (stat_crc_err == $past(addr_hit)));

    // R8
    pkt_rx_chk: assert property (@(posedge clk) disable iff (rst)
        eof |-> stat_pkt_rx);

    // R9
    intact_chk: assert property (@(posedge clk) disable iff (rst)
        eof |-> (stat_intact == ($past(addr_hit) && !stat_crc_err)));

    // R10
    stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(stat_bits) |-> (eof || $past(sync_hit)));

endmodule

bind lbk_rx lbk_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .crc_inhibit  (crc_inhibit),
    .addr_hit     (addr_hit),
    .byte_vld     (byte_vld),
    .eof          (eof),
    .byte_cnt     (byte_cnt),
    .stat_intact  (stat_intact),
    .stat_crc_err (stat_crc_err),
    .stat_pkt_rx  (stat_pkt_rx),
    .sync_hit     (sync_hit)
);

// File: tb/test_lbk_rx.sv
`timescale 1ns/1ps
module test_lbk_rx;

    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst;
    logic             bit_in;
    logic             bit_vld;
    logic             crc_inhibit;
    logic             addr_hit;
    logic [7:0]       byte_data;
    logic             byte_vld;
    logic             eof;
    logic [CNT_W-1:0] byte_cnt;
    logic             stat_intact;
    logic             stat_crc_err;
    logic             stat_pkt_rx;

    int tests = 0;
    int fails = 0;
    logic [7:0] tx [64];

    // {len[7:0], fcs_good, inhibit, hit, exp_err, exp_intact}
    localparam int NVEC = 7;
    localparam logic [12:0] VEC [NVEC] = '{
        {8'd6,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'd6,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'd10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd5,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'd7,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'd7,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    always #4 clk = ~clk;

    lbk_rx #(.CNT_W(CNT_W)) i_lbk_rx (
        .clk          (clk),
        .rst          (rst),
        .bit_in       (bit_in),
        .bit_vld      (bit_vld),
        .crc_inhibit  (crc_inhibit),
        .addr_hit     (addr_hit),
        .byte_data    (byte_data),
        .byte_vld     (byte_vld),
        .eof          (eof),
        .byte_cnt     (byte_cnt),
        .stat_intact  (stat_intact),
        .stat_crc_err (stat_crc_err),
        .stat_pkt_rx  (stat_pkt_rx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] bench_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < n; k++)
            for (int b = 0; b < 8; b++)
                c = {1'b0, c[31:1]} ^ ((c[0] ^ tx[k][b]) ? 32'hEDB88320 : 32'h0);
        return c;
    endfunction

    task automatic send_bit(input logic b, input logic v);
        @(negedge clk);
        bit_in  = b;
        bit_vld = v;
        @(posedge clk);
        #2;
    endtask

    // in_data: byte expected at the port; otherwise none expected
    task automatic send_byte(input logic [7:0] b, input bit in_data,
                             input int exp_cnt, input string req);
        bit early = 0;
        for (int i = 0; i < 8; i++) begin
            send_bit(b[i], 1'b1);
            if (i < 7 && byte_vld) early = 1;
        end
        if (in_data) begin
            chk(!early && byte_vld && byte_data == b, "R3", "byte", byte_data, b);
            chk(byte_cnt == exp_cnt, "R4", "count", byte_cnt, exp_cnt);
        end else begin
            chk(!early && !byte_vld && !eof, req, "no byte", byte_vld, 0);
            chk(byte_cnt == exp_cnt, req, "count", byte_cnt, exp_cnt);
        end
    endtask

    task automatic send_head(input int prev_cnt);
        for (int i = 0; i < 7; i++) send_byte(8'h55, 1'b0, prev_cnt, "R2");
        send_byte(8'hD5, 1'b0, 0, "R4");
        // R10: status cleared once the delimiter completes
        chk({stat_intact, stat_crc_err, stat_pkt_rx} == 3'b000, "R10", "clear",
            {stat_intact, stat_crc_err, stat_pkt_rx}, 0);
    endtask

    task automatic send_body(input int len, input int seed, input bit good);
        logic [31:0] c;
        for (int k = 0; k < len; k++) tx[k] = 8'((seed * 17) + (k * 29) + 3);
        c = ~bench_crc(len);
        for (int k = 0; k < 4; k++) tx[len + k] = c[8*k +: 8];
        if (!good) tx[len] = tx[len] ^ 8'h10;
        for (int k = 0; k < len + 4; k++) send_byte(tx[k], 1'b1, k + 1, "R3");
    endtask

    task automatic end_frame(input bit inh, input bit hit, input bit exp_err,
                             input bit exp_int, input int exp_cnt);
        logic [2:0] held;
        @(negedge clk);
        bit_vld     = 1'b0;
        bit_in      = 1'b0;
        crc_inhibit = inh;
        addr_hit    = hit;
        @(posedge clk);
        #2;
        chk(eof == 1'b1, "R5", "eof", eof, 1);
        chk(byte_cnt == exp_cnt, "R5", "count after end", byte_cnt, exp_cnt);
        chk(stat_pkt_rx == 1'b1, "R8", "pkt_rx", stat_pkt_rx, 1);
        chk(stat_crc_err == exp_err, inh ? "R7" : "R6", "crc_err", stat_crc_err, exp_err);
        chk(stat_intact == exp_int, "R9", "intact", stat_intact, exp_int);
        held = {stat_intact, stat_crc_err, stat_pkt_rx};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            crc_inhibit = ~crc_inhibit;
            addr_hit    = ~addr_hit;
            @(posedge clk);
            #2;
        end
        chk(eof == 1'b0, "R5", "eof one cycle", eof, 0);
        chk({stat_intact, stat_crc_err, stat_pkt_rx} == held, "R10", "held",
            {stat_intact, stat_crc_err, stat_pkt_rx}, held);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cnt;
        rst = 1'b1; bit_in = 1'b0; bit_vld = 1'b0; crc_inhibit = 1'b0; addr_hit = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(!byte_vld && !eof && byte_cnt == 0 && !stat_pkt_rx && !stat_crc_err && !stat_intact,
            "R1", "in reset", {byte_vld, eof, stat_pkt_rx}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        chk(!byte_vld && !eof && byte_cnt == 0 && !stat_pkt_rx && !stat_crc_err && !stat_intact,
            "R1", "after reset", {byte_vld, eof, stat_pkt_rx}, 0);

        // R2: noise with no delimiter, then a partly matched pattern broken by a gap
        send_byte(8'h00, 1'b0, 0, "R2");
        send_byte(8'hFF, 1'b0, 0, "R2");
        send_byte(8'h33, 1'b0, 0, "R2");
        send_byte(8'hCC, 1'b0, 0, "R2");
        send_byte(8'h55, 1'b0, 0, "R2");
        for (int i = 0; i < 6; i++) send_bit(i[0] ? 1'b0 : 1'b1, 1'b1);
        send_bit(1'b0, 1'b0);
        chk(!eof, "R2", "no eof while hunting", eof, 0);
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1);
        send_byte(8'h00, 1'b0, 0, "R2");
        chk(!byte_vld && byte_cnt == 0 && !eof, "R2", "broken pattern", byte_cnt, 0);

        // Vector table walk
        cnt = 0;
        for (int v = 0; v < NVEC; v++) begin
            int len = int'(VEC[v][12:5]);
            send_head(cnt);
            send_body(len, v, VEC[v][4]);
            cnt = len + 4;
            end_frame(VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0], cnt);
        end

        // R5: trailing partial bits discarded; CRC still good
        send_head(cnt);
        send_body(4, 9, 1'b1);
        for (int i = 0; i < 5; i++) begin
            send_bit(i[0], 1'b1);
            chk(!byte_vld && byte_cnt == 8, "R5", "partial bits", byte_cnt, 8);
        end
        end_frame(1'b0, 1'b1, 1'b0, 1'b1, 8);

        // R6: bad CRC reported even on address miss without inhibit
        send_head(8);
        send_body(2, 11, 1'b0);
        end_frame(1'b0, 1'b0, 1'b1, 1'b0, 6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule